// File: doc/BRIEF.md
# Clock Loss and Lock Status Monitor

This block watches the clocks around a frequency synthesizer and reports their health to software. It tracks three slow clocks sampled by a faster system clock: a crystal clock, an external clock input and the feedback clock that returns from the synthesizer's divider. Each of the two reference candidates has its own loss-of-signal detector, which fires when no rising edge has been seen for a programmable number of system cycles. One of the two candidates is chosen as the reference for the phase detector. A windowed frequency comparison counts feedback edges over a fixed number of reference edges and judges the loop unlocked when the counts differ by more than a threshold given in parts per million.

A lock state machine turns the window results into a calibration flag and a loss-of-lock flag. Its states are PAUSED (monitoring suspended), CAL (lock being acquired), LOCKED and UNLOCKED. Transitions: any state goes to PAUSED while the pause bit is set; any unpaused state goes to CAL on a soft reset; PAUSED goes to CAL when the pause bit is cleared; CAL goes to LOCKED after the programmed number of consecutive good windows; LOCKED goes to UNLOCKED on a bad window or when the selected reference is lost; UNLOCKED goes to CAL on a good window. Reset enters CAL.

Four live flags and their sticky copies are readable through a simple register port, together with an interrupt mask and a control register. The interrupt output requests an open-drain pad to pull low whenever an unmasked sticky flag is set.

Top module: `clk_health_mon`

## Requirements
- R1: Loss of lock (status bit 0) is raised when, in LOCKED, a window ends with a bad comparison or the selected reference reports loss of signal; it stays raised until a good window moves the machine to CAL.
- R2: A window spans 2^WIN_LOG2 reference rising edges; it is bad when the feedback edge count differs from 2^WIN_LOG2 by more than floor(2^WIN_LOG2 * LOL_PPM / 10^6), and good otherwise.
- R3: Each reference candidate has a loss-of-signal flag (crystal at status bit 3, external input at status bit 2) that sets after LOS_CYC system cycles without a rising edge and clears within a few cycles of the next rising edge.
- R4: The calibration flag (status bit 1) is set after reset and after writing 1 to control bit 2 (soft reset, reads back 0), and clears once the number of consecutive good windows in control bits 7:4 is reached (0 behaves as 1).
- R5: Register 1 holds sticky copies of the four flags at the same bit positions; a sticky bit sets whenever its live flag is 1, clears when 1 is written to it while the live flag is 0, and is unchanged by writing 0.
- R6: Register 2 holds the mask (bit = 1 suppresses); irq_pull_low_o is 1 exactly when some sticky bit is set with its mask bit 0, and status bit 7 reads the same value.
- R7: While control bit 0 (pause) is 1, loss of lock and calibration read 0 and the window counters are held clear; clearing the bit enters CAL with fresh windows.
- R8: Control bit 1 selects the reference: 0 the crystal clock, 1 the external clock; the unselected input's loss of signal does not affect the lock state.
- R9: After reset, status reads 0x02, the mask reads 0x0F, control reads 0x20 for the default CALW_RST of 2, and the interrupt is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_clk_i | input | 1 | Crystal reference clock (asynchronous, slower than clk) |
| ext_clk_i | input | 1 | External reference clock (asynchronous) |
| fb_clk_i | input | 1 | Feedback clock from the synthesizer divider (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 status, 1 sticky, 2 mask, 3 control |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| irq_pull_low_o | output | 1 | 1 asks the open-drain interrupt pad to drive low |

## Verification
The embedded assertions watch every cycle that a loss-of-signal flag drops after an edge, that window results never come back to back, that loss of lock only rises from a bad window or a lost reference, that pause forces loss of lock low, that a soft reset lands in calibration, and that sticky bits never miss a live flag. The ppm threshold on both sides, the number of good windows needed to leave calibration, the reference selection, the mask and write-one-to-clear behaviour and the recovery after pause can only be shown by the bench's scenarios, which run clocks at chosen period ratios and read the registers after whole windows.

// File: rtl/clk_health_mon_pkg.sv
package clk_health_mon_pkg;

    typedef enum logic [1:0] {
        ST_PAUSED,
        ST_CAL,
        ST_LOCKED,
        ST_UNLOCKED
    } lock_state_e;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_STICKY = 2'd1;
    localparam logic [1:0] ADDR_MASK   = 2'd2;
    localparam logic [1:0] ADDR_CTRL   = 2'd3;

    localparam int FLAG_LOL      = 0;
    localparam int FLAG_CAL      = 1;
    localparam int FLAG_EXT_LOS  = 2;
    localparam int FLAG_XTAL_LOS = 3;
    localparam int NUM_FLAGS     = 4;

    localparam int CTRL_PAUSE = 0;
    localparam int CTRL_SRC   = 1;
    localparam int CTRL_SRST  = 2;

endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
    parameter int LANES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_i,
    output logic [LANES-1:0] rise_o
);
    // Two synchronizer stages plus one history stage per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [2:0] shift_q;
        always_ff @(posedge clk) begin
            if (!rst_n) shift_q <= '0;
            else        shift_q <= {shift_q[1:0], async_i[g]};
        end
        assign rise_o[g] = shift_q[1] & ~shift_q[2];
    end
endmodule

// File: rtl/cm_activity_det.sv
module cm_activity_det #(
    parameter int LOS_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic los_o
);
    localparam int CW = $clog2(LOS_CYC + 1);
    typedef logic [CW-1:0] cnt_t;
    localparam cnt_t LIMIT = cnt_t'(LOS_CYC);

    cnt_t idle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
            los_o  <= 1'b0;
        end else if (rise_i) begin
            idle_q <= '0;
            los_o  <= 1'b0;
        end else if (idle_q == LIMIT) begin
            los_o  <= 1'b1;
        end else begin
            idle_q <= idle_q + cnt_t'(1);
        end
    end

    AST_LOS_DROPS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> !los_o); // R3
endmodule

// File: rtl/cm_freq_cmp.sv
module cm_freq_cmp #(
    parameter int WIN_LOG2 = 16,
    parameter int LOL_PPM  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    output logic done_o,
    output logic bad_o
);
    localparam int CW = WIN_LOG2 + 2;
    typedef logic [WIN_LOG2-1:0] rcnt_t;
    typedef logic [CW-1:0]       fcnt_t;
    localparam longint unsigned THR_L =
        ((64'd1 << WIN_LOG2) * 64'(LOL_PPM)) / 64'd1000000;
    localparam fcnt_t THR  = fcnt_t'(THR_L);
    localparam fcnt_t FULL = fcnt_t'(1) << WIN_LOG2;

    rcnt_t ref_q;
    fcnt_t fb_q;
    fcnt_t fb_tot;
    fcnt_t diff;
    logic  last;

    always_comb begin
        fb_tot = fb_q + fcnt_t'(fb_rise_i);
        diff   = (fb_tot >= FULL) ? (fb_tot - FULL) : (FULL - fb_tot);
        last   = ref_rise_i && (ref_q == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ref_q  <= '0;
            fb_q   <= '0;
            done_o <= 1'b0;
            bad_o  <= 1'b0;
        end else begin
            done_o <= last;
            bad_o  <= last && (diff > THR);
            if (last) begin
                ref_q <= '0;
                fb_q  <= '0;
            end else begin
                ref_q <= ref_q + rcnt_t'(ref_rise_i);
                if (fb_q != '1) fb_q <= fb_tot;
            end
        end
    end

    AST_WINDOW_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
endmodule

// File: rtl/cm_lock_fsm.sv
module cm_lock_fsm
    import clk_health_mon_pkg::*;
#(
    parameter int CALW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pause_i,
    input  logic              soft_rst_i,
    input  logic              win_done_i,
    input  logic              win_bad_i,
    input  logic              ref_los_i,
    input  logic [CALW_W-1:0] cal_win_i,
    output logic              lol_o,
    output logic              cal_o
);
    lock_state_e        state_q, state_d;
    logic [CALW_W-1:0]  good_q;
    logic [CALW_W:0]    good_next;
    logic [CALW_W:0]    need;
    logic               good_hit, bad_hit;

    always_comb begin
        good_hit  = win_done_i && !win_bad_i;
        bad_hit   = win_done_i &&  win_bad_i;
        good_next = {1'b0, good_q} + {{CALW_W{1'b0}}, 1'b1};
        need      = (cal_win_i == '0) ? {{CALW_W{1'b0}}, 1'b1} : {1'b0, cal_win_i};
    end

    always_comb begin
        state_d = state_q;
        if (pause_i) begin
            state_d = ST_PAUSED;
        end else if (soft_rst_i) begin
            state_d = ST_CAL;
        end else begin
            unique case (state_q)
                ST_PAUSED:   state_d = ST_CAL;
                ST_CAL:      if (good_hit && (good_next >= need)) state_d = ST_LOCKED;
                ST_LOCKED:   if (bad_hit || ref_los_i)            state_d = ST_UNLOCKED;
                ST_UNLOCKED: if (good_hit)                        state_d = ST_CAL;
                default:     state_d = ST_CAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CAL;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_CAL || state_d != ST_CAL || bad_hit) good_q <= '0;
            else if (good_hit)                                     good_q <= good_next[CALW_W-1:0];
        end
    end

    always_comb begin
        lol_o = (state_q == ST_UNLOCKED);
        cal_o = (state_q == ST_CAL);
    end

    AST_PAUSE_HOLDS_LOL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |=> !lol_o); // R7
    AST_LOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_o) |-> ($past(win_done_i && win_bad_i) || $past(ref_los_i))); // R1
    AST_SOFT_RST_TO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && !pause_i) |=> cal_o); // R4
endmodule

// File: rtl/cm_status_regs.sv
module cm_status_regs
    import clk_health_mon_pkg::*;
#(
    parameter int CALW_W   = 4,
    parameter int CALW_RST = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] live_i,
    input  logic                 wr_i,
    input  logic [1:0]           addr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    output logic                 irq_o,
    output logic                 pause_o,
    output logic                 src_ext_o,
    output logic                 soft_rst_o,
    output logic [CALW_W-1:0]    cal_win_o
);
    logic [NUM_FLAGS-1:0] sticky_q;
    logic [NUM_FLAGS-1:0] mask_q;
    logic [NUM_FLAGS-1:0] w1c;

    always_comb begin
        w1c        = (wr_i && addr_i == ADDR_STICKY) ? wdata_i[NUM_FLAGS-1:0] : '0;
        soft_rst_o = wr_i && (addr_i == ADDR_CTRL) && wdata_i[CTRL_SRST];
        irq_o      = |(sticky_q & ~mask_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q  <= '0;
            mask_q    <= '1;
            pause_o   <= 1'b0;
            src_ext_o <= 1'b0;
            cal_win_o <= CALW_W'(CALW_RST);
        end else begin
            sticky_q <= (sticky_q & ~w1c) | live_i;
            if (wr_i && addr_i == ADDR_MASK) mask_q <= wdata_i[NUM_FLAGS-1:0];
            if (wr_i && addr_i == ADDR_CTRL) begin
                pause_o   <= wdata_i[CTRL_PAUSE];
                src_ext_o <= wdata_i[CTRL_SRC];
                cal_win_o <= wdata_i[7:8-CALW_W];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_STATUS: begin
                rdata_o[NUM_FLAGS-1:0] = live_i;
                rdata_o[7]             = irq_o;
            end
            ADDR_STICKY: rdata_o[NUM_FLAGS-1:0] = sticky_q;
            ADDR_MASK:   rdata_o[NUM_FLAGS-1:0] = mask_q;
            ADDR_CTRL: begin
                rdata_o[CTRL_PAUSE] = pause_o;
                rdata_o[CTRL_SRC]   = src_ext_o;
                rdata_o[7:8-CALW_W] = cal_win_o;
            end
            default: rdata_o = '0;
        endcase
    end

    AST_STICKY_CATCHES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (|live_i) |=> ((sticky_q & $past(live_i)) == $past(live_i))); // R5
endmodule

// File: rtl/clk_health_mon.sv
module clk_health_mon
    import clk_health_mon_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int LOL_PPM  = 1000,
    parameter int LOS_CYC  = 300,
    parameter int CALW_RST = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_clk_i,
    input  logic       ext_clk_i,
    input  logic       fb_clk_i,
    input  logic       bus_wr_i,
    input  logic [1:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       irq_pull_low_o
);
    localparam int CALW_W   = 4;
    localparam int LANE_XT  = 0;
    localparam int LANE_EX  = 1;
    localparam int LANE_FB  = 2;
    localparam int N_LANES  = 3;
    localparam int N_LOS    = 2;

    logic [N_LANES-1:0]   rise;
    logic [N_LOS-1:0]     los;
    logic                 ref_rise, ref_los;
    logic                 win_done, win_bad;
    logic                 lol, cal;
    logic                 pause, src_ext, soft_rst;
    logic [CALW_W-1:0]    cal_win;
    logic [NUM_FLAGS-1:0] live;

    cm_edge_sync #(.LANES(N_LANES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({fb_clk_i, ext_clk_i, xtal_clk_i}),
        .rise_o  (rise)
    );

    for (genvar g = 0; g < N_LOS; g++) begin : g_los
        cm_activity_det #(.LOS_CYC(LOS_CYC)) u_act (
            .clk    (clk),
            .rst_n  (rst_n),
            .rise_i (rise[g]),
            .los_o  (los[g])
        );
    end

    always_comb begin
        ref_rise = src_ext ? rise[LANE_EX] : rise[LANE_XT];
        ref_los  = src_ext ? los[LANE_EX]  : los[LANE_XT];
        live                = '0;
        live[FLAG_LOL]      = lol;
        live[FLAG_CAL]      = cal;
        live[FLAG_EXT_LOS]  = los[LANE_EX];
        live[FLAG_XTAL_LOS] = los[LANE_XT];
    end

    cm_freq_cmp #(.WIN_LOG2(WIN_LOG2), .LOL_PPM(LOL_PPM)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (pause | soft_rst),
        .ref_rise_i (ref_rise),
        .fb_rise_i  (rise[LANE_FB]),
        .done_o     (win_done),
        .bad_o      (win_bad)
    );

    cm_lock_fsm #(.CALW_W(CALW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_i    (pause),
        .soft_rst_i (soft_rst),
        .win_done_i (win_done),
        .win_bad_i  (win_bad),
        .ref_los_i  (ref_los),
        .cal_win_i  (cal_win),
        .lol_o      (lol),
        .cal_o      (cal)
    );

    cm_status_regs #(.CALW_W(CALW_W), .CALW_RST(CALW_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_i     (live),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .irq_o      (irq_pull_low_o),
        .pause_o    (pause),
        .src_ext_o  (src_ext),
        .soft_rst_o (soft_rst),
        .cal_win_o  (cal_win)
    );
endmodule

// File: tb/tb_clk_health_mon.sv
module tb_clk_health_mon;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal = 1'b0, ext = 1'b0, fb = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int  xtal_half = 40, ext_half = 40, fb_half = 40;
    bit  xtal_run = 1'b1, ext_run = 1'b1, fb_run = 1'b1;
    int  checks = 0, errors = 0, pending = 0;

    typedef struct {
        logic [1:0] addr;
        logic [7:0] cmp;
        logic [7:0] exp;
        bit         chk_irq;
        logic       irq_exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    clk_health_mon #(.WIN_LOG2(6), .LOL_PPM(100000), .LOS_CYC(40), .CALW_RST(2)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .xtal_clk_i     (xtal),
        .ext_clk_i      (ext),
        .fb_clk_i       (fb),
        .bus_wr_i       (bus_wr),
        .bus_addr_i     (bus_addr),
        .bus_wdata_i    (bus_wdata),
        .bus_rdata_o    (bus_rdata),
        .irq_pull_low_o (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin #3; forever begin if (xtal_run) begin #(xtal_half); xtal = ~xtal; end else #(CLK_PERIOD); end end
    initial begin #5; forever begin if (ext_run)  begin #(ext_half);  ext  = ~ext;  end else #(CLK_PERIOD); end end
    initial begin #7; forever begin if (fb_run)   begin #(fb_half);   fb   = ~fb;   end else #(CLK_PERIOD); end end

    // Monitor: pops expected items and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                bus_addr = it.addr;
                #1;
                checks++;
                if ((bus_rdata & it.cmp) !== (it.exp & it.cmp)) begin
                    errors++;
                    $display("FAIL %s: reg %0d actual 0x%02h expected 0x%02h",
                             it.tag, it.addr, bus_rdata & it.cmp, it.exp & it.cmp);
                end
                if (it.chk_irq) begin
                    checks++;
                    if (irq !== it.irq_exp) begin
                        errors++;
                        $display("FAIL %s: irq actual %0b expected %0b", it.tag, irq, it.irq_exp);
                    end
                end
                pending--;
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] m, input logic [7:0] e,
                              input bit ci, input logic ie, input string tag);
        item_t it;
        it.addr = a; it.cmp = m; it.exp = e; it.chk_irq = ci; it.irq_exp = ie; it.tag = tag;
        pending++;
        sb_q.push_back(it);
        wait (pending == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        // R9 reset state
        expect_reg(2'd0, 8'hFF, 8'h02, 1, 1'b0, "R9 status after reset");
        expect_reg(2'd2, 8'hFF, 8'h0F, 0, 1'b0, "R9 mask after reset");
        expect_reg(2'd3, 8'hFF, 8'h20, 0, 1'b0, "R9 control after reset");
        // R4 calibration ends after two good windows
        cycles(1500);
        expect_reg(2'd0, 8'hFF, 8'h00, 0, 1'b0, "R4 locked after calibration");
        expect_reg(2'd1, 8'h0F, 8'h02, 0, 1'b0, "R5 sticky holds calibration");
        // R5 write-0 no effect, write-1 clears
        wr(2'd1, 8'h00);
        expect_reg(2'd1, 8'h0F, 8'h02, 0, 1'b0, "R5 write zero keeps sticky");
        wr(2'd1, 8'h02);
        expect_reg(2'd1, 8'h0F, 8'h00, 0, 1'b0, "R5 write one clears sticky");
        // R3 / R8 external input LOS while crystal is reference
        ext_run = 1'b0;
        cycles(80);
        expect_reg(2'd0, 8'hFF, 8'h04, 0, 1'b0, "R3 ext LOS set, R8 lock kept");
        ext_run = 1'b1;
        cycles(20);
        expect_reg(2'd0, 8'hFF, 8'h00, 0, 1'b0, "R3 ext LOS cleared");
        expect_reg(2'd1, 8'h0F, 8'h04, 0, 1'b0, "R5 ext LOS sticky");
        // R6 mask and interrupt
        wr(2'd2, 8'h0B);
        expect_reg(2'd0, 8'hFF, 8'h80, 1, 1'b1, "R6 unmasked sticky raises irq");
        wr(2'd1, 8'h04);
        expect_reg(2'd0, 8'hFF, 8'h00, 1, 1'b0, "R6 irq drops after clear");
        wr(2'd2, 8'h0F);
        // R2 just over threshold: feedback 92 vs reference 80
        fb_half = 46;
        cycles(1800);
        expect_reg(2'd0, 8'h0F, 8'h01, 0, 1'b0, "R2 over threshold gives LOL");
        // R2 within threshold: feedback 84 vs reference 80
        fb_half = 42;
        cycles(2800);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R2 within threshold relocks");
        // R1 large frequency error
        fb_half = 50;
        cycles(1800);
        expect_reg(2'd0, 8'h0F, 8'h01, 0, 1'b0, "R1 LOL on frequency error");
        // R7 pause
        wr(2'd3, 8'h21);
        cycles(4);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R7 pause clears LOL");
        fb_half = 40;
        cycles(1000);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R7 held while paused");
        wr(2'd3, 8'h20);
        cycles(4);
        expect_reg(2'd0, 8'h0F, 8'h02, 0, 1'b0, "R7 resume enters calibration");
        cycles(1300);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R7 lock after resume");
        // R4 soft reset with four windows
        wr(2'd3, 8'h44);
        cycles(4);
        expect_reg(2'd0, 8'h0F, 8'h02, 0, 1'b0, "R4 soft reset sets calibration");
        expect_reg(2'd3, 8'hFF, 8'h40, 0, 1'b0, "R4 soft reset bit reads zero");
        cycles(1500);
        expect_reg(2'd0, 8'h0F, 8'h02, 0, 1'b0, "R4 still calibrating before four windows");
        cycles(1000);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R4 calibration done after four windows");
        // R8 external reference
        wr(2'd3, 8'h41);
        ext_half = 50; fb_half = 50;
        cycles(20);
        wr(2'd3, 8'h42);
        cycles(3000);
        expect_reg(2'd0, 8'h0F, 8'h00, 0, 1'b0, "R8 locked to external reference");
        xtal_run = 1'b0;
        cycles(80);
        expect_reg(2'd0, 8'h0F, 8'h08, 0, 1'b0, "R8 crystal LOS does not unlock");
        // R1 loss of the selected reference
        ext_run = 1'b0;
        cycles(80);
        expect_reg(2'd0, 8'h0F, 8'h0D, 0, 1'b0, "R1 LOL on reference LOS");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule